// File: doc/BRIEF.md
# Edge-Triggered Up/Down Tally Counter

This block is a synchronous counter with two independent request inputs: one asks for a step up and the other asks for a step down. A request counts only on its rising edge, so holding a request high gives exactly one step. The block samples both requests on the system clock and compares each with a registered copy of its previous value. A level-sensitive clear input and a level-sensitive load input override counting. Clear forces the count to zero. Load copies a run-time preset value into the count.

Two combinational flags are derived from the registered count. One flag says the count is at or above the preset. The other flag says the count is at or below zero. The count width is a parameter, and a second parameter chooses two's-complement or unsigned arithmetic when the block is built. The count saturates at both ends of its range and never wraps.

A small sequencer has two states. After the asynchronous system reset it sits in `ST_PRIME` for exactly one clock, and during that clock the input history is captured but no edge may count. It then takes the transition PRIME_TO_RUN into `ST_RUN`. The only way out of `ST_RUN` is RUN_TO_PRIME, taken by asserting the system reset. In `ST_RUN`, a per-cycle action is chosen from `ACT_CLEAR`, `ACT_LOAD`, `ACT_UP`, `ACT_DOWN` and `ACT_HOLD`.

Top module: `updown_tally`

## Requirements
- R1: A rising edge on `up_req` (low at the previous clock edge, high at this one) raises `count` by one at that clock edge. Holding `up_req` high gives no further steps.
- R2: A rising edge on `dn_req` lowers `count` by one at that clock edge. Holding `dn_req` high gives no further steps.
- R3: When rising edges on `up_req` and `dn_req` fall on the same clock edge, `count` is unchanged.
- R4: While `clear` is high at a clock edge, `count` becomes zero. This holds whatever `load` and the request inputs do.
- R5: When `load` is high and `clear` is low at a clock edge, `count` takes the value of `preset`, and any request edge in that cycle is discarded.
- R6: With `IS_SIGNED`=1, counting up stops at the largest positive value (0x7F for W=8) and counting down stops at the most negative value (0x80 for W=8).
- R7: With `IS_SIGNED`=0, counting up stops at all ones and counting down stops at zero.
- R8: `hit_target` is 1 exactly when `count` >= `preset`. The comparison is signed when `IS_SIGNED`=1 and unsigned otherwise.
- R9: `at_floor` is 1 exactly when `count` <= 0. That means a negative or zero value when signed, and zero when unsigned.
- R10: After `rst_n` is released, a request input that was already high produces no step. After reset, `count` is zero.
- R11: A request that rises while `clear` or `load` is high is consumed. It does not count once the override is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clear | input | 1 | Level-sensitive clear of the count, highest priority |
| load | input | 1 | Level-sensitive load of `preset` into the count |
| up_req | input | 1 | Count-up request, acts on its rising edge |
| dn_req | input | 1 | Count-down request, acts on its rising edge |
| preset | input | W | Programmed value for load and for the target comparison |
| count | output | W | Current count value |
| hit_target | output | 1 | Count is at or above `preset` |
| at_floor | output | 1 | Count is at or below zero |

## Verification
The bench holds a request high through reset and through a clear. A design with a history register that reset to zero, or that stopped tracking during overrides, would show a phantom step there. It drives simultaneous up and down edges and a load coinciding with an edge, where a design with the wrong priority order would move the count by one. It also pushes the count past both range limits in a signed 8-bit instance and an unsigned 4-bit instance, where a wrapping counter would jump to the opposite end. Finally, it picks presets whose sign bit is set, where a flag comparison with the wrong signedness would invert `hit_target`.

// File: rtl/tally_pkg.sv
package tally_pkg;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } seq_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_UP    = 3'd3,
        ACT_DOWN  = 3'd4
    } tally_act_t;

    localparam int NUM_REQ = 2;
    localparam int REQ_UP  = 0;
    localparam int REQ_DN  = 1;

endpackage

// File: rtl/tally_edge_detect.sv
module tally_edge_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] hist_q;

    for (genvar g = 0; g < N; g++) begin : g_lane
        // History always follows the input, including in the priming cycle,
        // so a level present at reset release is never seen as an edge.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_q[g] <= 1'b0;
            end else begin
                hist_q[g] <= din[g];
            end
        end
        assign rise[g] = arm & din[g] & ~hist_q[g];
    end
endmodule

// File: rtl/tally_ctrl.sv
module tally_ctrl
    import tally_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic       up_rise,
    input  logic       dn_rise,
    output logic       arm,
    output tally_act_t act
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;   // PRIME_TO_RUN
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_comb begin
        arm = 1'b0;
        act = ACT_HOLD;
        unique case (state_q)
            ST_PRIME: begin
                arm = 1'b0;
                if (clear)     act = ACT_CLEAR;
                else if (load) act = ACT_LOAD;
                else           act = ACT_HOLD;
            end
            ST_RUN: begin
                arm = 1'b1;
                if (clear)                    act = ACT_CLEAR;
                else if (load)                act = ACT_LOAD;
                else if (up_rise && !dn_rise) act = ACT_UP;
                else if (dn_rise && !up_rise) act = ACT_DOWN;
                else                          act = ACT_HOLD;
            end
            default: begin
                arm = 1'b0;
                act = ACT_HOLD;
            end
        endcase
    end
endmodule

// File: rtl/tally_core.sv
module tally_core
    import tally_pkg::*;
#(
    parameter int W         = 8,
    parameter bit IS_SIGNED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tally_act_t   act,
    input  logic [W-1:0] preset,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MAXV = IS_SIGNED ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
    localparam logic [W-1:0] MINV = IS_SIGNED ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] value_d;

    always_comb begin
        value_d = value;
        unique case (act)
            ACT_CLEAR: value_d = '0;
            ACT_LOAD:  value_d = preset;
            ACT_UP:    value_d = (value == MAXV) ? value : value + ONE;
            ACT_DOWN:  value_d = (value == MINV) ? value : value - ONE;
            ACT_HOLD:  value_d = value;
            default:   value_d = value;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            value <= value_d;
        end
    end
endmodule

// File: rtl/tally_flags.sv
module tally_flags #(
    parameter int W         = 8,
    parameter bit IS_SIGNED = 1'b1
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] preset,
    output logic         hit_target,
    output logic         at_floor
);
    if (IS_SIGNED) begin : g_signed
        assign hit_target = $signed(value) >= $signed(preset);
        assign at_floor   = value[W-1] | (value == '0);
    end else begin : g_unsigned
        assign hit_target = value >= preset;
        assign at_floor   = (value == '0);
    end
endmodule

// File: rtl/updown_tally.sv
module updown_tally
    import tally_pkg::*;
#(
    parameter int W         = 8,
    parameter bit IS_SIGNED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         up_req,
    input  logic         dn_req,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         hit_target,
    output logic         at_floor
);
    logic [NUM_REQ-1:0] req_vec;
    logic [NUM_REQ-1:0] rise_vec;
    logic               arm;
    tally_act_t         act;

    assign req_vec[REQ_UP] = up_req;
    assign req_vec[REQ_DN] = dn_req;

    tally_edge_detect #(.N(NUM_REQ)) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm),
        .din  (req_vec),
        .rise (rise_vec)
    );

    tally_ctrl ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .load   (load),
        .up_rise(rise_vec[REQ_UP]),
        .dn_rise(rise_vec[REQ_DN]),
        .arm    (arm),
        .act    (act)
    );

    tally_core #(.W(W), .IS_SIGNED(IS_SIGNED)) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .preset(preset),
        .value (count)
    );

    tally_flags #(.W(W), .IS_SIGNED(IS_SIGNED)) flags_i (
        .value     (count),
        .preset    (preset),
        .hit_target(hit_target),
        .at_floor  (at_floor)
    );
endmodule

// File: rtl/tally_checker.sv
module tally_checker #(
    parameter int W         = 8,
    parameter bit IS_SIGNED = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear,
    input logic         load,
    input logic         up_req,
    input logic         dn_req,
    input logic [W-1:0] preset,
    input logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = IS_SIGNED ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
    localparam logic [W-1:0] MINV = IS_SIGNED ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    // R4: clear wins over everything
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // R5: load without clear copies the preset
    a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load) |=> (count == $past(preset)));

    // R1 / R2: no request high means no movement
    a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && !up_req && !dn_req) |=> $stable(count));

    // R2 / R3: counting moves at most one step per cycle
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load) |=> (count == $past(count) ||
                               count == $past(count) + ONE ||
                               count == $past(count) - ONE));

    // R6 / R7: no wrap past the top
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && !dn_req && count == MAXV) |=> (count == MAXV));

    // R6 / R7: no wrap past the bottom
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && !up_req && count == MINV) |=> (count == MINV));
endmodule

bind updown_tally tally_checker #(.W(W), .IS_SIGNED(IS_SIGNED)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .load  (load),
    .up_req(up_req),
    .dn_req(dn_req),
    .preset(preset),
    .count (count)
);

// File: tb/updown_tally_tb_top.sv
module updown_tally_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    logic       s_clear = 1'b0, s_load = 1'b0, s_up = 1'b0, s_dn = 1'b0;
    logic [7:0] s_preset = 8'd0;
    logic [7:0] s_count;
    logic       s_hit, s_floor;

    logic       u_clear = 1'b0, u_load = 1'b0, u_up = 1'b0, u_dn = 1'b0;
    logic [3:0] u_preset = 4'd0;
    logic [3:0] u_count;
    logic       u_hit, u_floor;

    updown_tally #(.W(8), .IS_SIGNED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear(s_clear), .load(s_load),
        .up_req(s_up), .dn_req(s_dn), .preset(s_preset),
        .count(s_count), .hit_target(s_hit), .at_floor(s_floor)
    );

    updown_tally #(.W(4), .IS_SIGNED(1'b0)) dut_u (
        .clk(clk), .rst_n(rst_n), .clear(u_clear), .load(u_load),
        .up_req(u_up), .dn_req(u_dn), .preset(u_preset),
        .count(u_count), .hit_target(u_hit), .at_floor(u_floor)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_up_s();
        s_up = 1'b1; step(); s_up = 1'b0; step();
    endtask

    task automatic pulse_dn_s();
        s_dn = 1'b1; step(); s_dn = 1'b0; step();
    endtask

    task automatic t_reset();
        // R10: up request already high through reset release
        s_up = 1'b1; u_dn = 1'b1; s_preset = 8'd5;
        repeat (2) step();
        rst_n = 1'b1;
        repeat (3) step();
        chk("R10 no step after reset", $signed(s_count), 0);
        chk("R10 unsigned count after reset", int'(u_count), 0);
        chk("R9 floor at zero", int'(s_floor), 1);
        chk("R8 target clear 0<5", int'(s_hit), 0);
        s_up = 1'b0; u_dn = 1'b0; step();
        chk("R10 falling level no step", $signed(s_count), 0);
    endtask

    task automatic t_count_up();
        s_up = 1'b1; step();
        chk("R1 first edge", $signed(s_count), 1);
        step(); step();
        chk("R1 held level no step", $signed(s_count), 1);
        s_up = 1'b0; step();
        pulse_up_s(); pulse_up_s();
        chk("R1 three edges", $signed(s_count), 3);
        chk("R8 target 3<5", int'(s_hit), 0);
        pulse_up_s(); pulse_up_s();
        chk("R8 target 5>=5", int'(s_hit), 1);
        chk("R9 floor off at 5", int'(s_floor), 0);
    endtask

    task automatic t_count_down();
        s_dn = 1'b1; step(); step();
        chk("R2 one step while held", $signed(s_count), 4);
        s_dn = 1'b0; step();
        for (int i = 0; i < 6; i++) pulse_dn_s();
        chk("R2 down into negative", $signed(s_count), -2);
        chk("R9 floor negative", int'(s_floor), 1);
    endtask

    task automatic t_both();
        s_up = 1'b1; s_dn = 1'b1; step();
        chk("R3 simultaneous edges hold", $signed(s_count), -2);
        s_up = 1'b0; step();
        chk("R3 still held after up falls", $signed(s_count), -2);
        s_dn = 1'b0; step();
    endtask

    task automatic t_priority();
        s_preset = 8'd20;
        s_clear = 1'b1; s_load = 1'b1; step();
        chk("R4 clear beats load", $signed(s_count), 0);
        s_clear = 1'b0; s_up = 1'b1; step();
        chk("R5 load beats edge", $signed(s_count), 20);
        s_load = 1'b0; step();
        chk("R11 edge under load consumed", $signed(s_count), 20);
        s_up = 1'b0; s_clear = 1'b1; step();
        s_dn = 1'b1; step();
        s_clear = 1'b0; step();
        chk("R11 edge under clear consumed", $signed(s_count), 0);
        s_dn = 1'b0; step();
    endtask

    task automatic t_sat_signed();
        s_preset = 8'h7F; s_load = 1'b1; step(); s_load = 1'b0;
        pulse_up_s();
        chk("R6 signed top 0x7F", int'(s_count), 127);
        chk("R8 target at max", int'(s_hit), 1);
        s_preset = 8'h80; s_load = 1'b1; step(); s_load = 1'b0;
        pulse_dn_s();
        chk("R6 signed bottom 0x80", int'(s_count), 128);
        chk("R9 floor at most negative", int'(s_floor), 1);
        chk("R8 -128>=-128", int'(s_hit), 1);
        s_preset = 8'hF0;  // -16
        step();
        chk("R8 signed -128<-16", int'(s_hit), 0);
    endtask

    task automatic t_unsigned();
        u_preset = 4'd15; u_load = 1'b1; step(); u_load = 1'b0;
        u_up = 1'b1; step(); u_up = 1'b0; step();
        chk("R7 unsigned top 15", int'(u_count), 15);
        chk("R9 unsigned floor off", int'(u_floor), 0);
        u_clear = 1'b1; step(); u_clear = 1'b0;
        u_dn = 1'b1; step(); u_dn = 1'b0; step();
        chk("R7 unsigned bottom 0", int'(u_count), 0);
        chk("R9 unsigned floor zero", int'(u_floor), 1);
        u_preset = 4'd3; u_load = 1'b1; step(); u_load = 1'b0;
        u_preset = 4'd8; step();
        chk("R8 unsigned 3<8", int'(u_hit), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        step();
        t_reset();
        t_count_up();
        t_count_down();
        t_both();
        t_priority();
        t_sat_signed();
        t_unsigned();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule